// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

The engine moves received packets from a byte stream into host memory. The host prepares a ring of 8-byte descriptors in a shared 16-bit memory. Each descriptor names a buffer. For each packet the engine walks the ring from its current index and fills one buffer after another with the stream bytes. When the packet ends, it reports the total length plus four. Each descriptor it has used is handed back to the host by clearing the ownership bit.

Memory is reached through a single-issue port. Reads return data one cycle after the request. Writes carry byte enables, and stream bytes are packed little-endian into 16-bit words. The stream is held off with `s_ready_o` while no usable descriptor is available, while the engine is disabled, and after a descriptor with an illegal buffer size has stopped it. A one-cycle interrupt pulse marks each completed packet.

Top module: `rx_ring_engine`

## Requirements
- R1: Descriptor i lives at byte address ring_base + 8*i, as four 16-bit words w0..w3. The buffer byte address is {w1[7:0], w0}, and the buffer size is 4096 minus w2[11:0].
- R2: A descriptor with w1[15] (owner) clear, or with w2[15:12] other than 4'hF, is not used. The engine re-reads it, keeps `s_ready_o` low and writes nothing until it becomes valid.
- R3: A valid, owned descriptor whose size is below 12 or above 1900 stops the engine. It then makes no memory writes and keeps `s_ready_o` low until `rx_on_i` is dropped, and the descriptor is left unchanged.
- R4: Each buffer takes bytes until it is full or the packet's last byte has arrived. The rest of the packet continues in the next descriptor. Bytes past the packet end are not written.
- R5: Write-back of w1 sets bit 9 (start flag) on the first descriptor of a packet and clears it on every later one.
- R6: Write-back of w1 sets bit 8 (end flag) only on the descriptor holding the last byte. That descriptor's w3[11:0] becomes the packet length plus 4, and w3[15:12] is kept. Other descriptors keep w3 as read, and w2 is always written back unchanged.
- R7: Write-back of w1 clears bit 15 and keeps bits 14:10 and 7:0.
- R8: `rint_o` is high for exactly one cycle per completed packet, in the cycle after the w3 write of its last descriptor.
- R9: The ring index advances after each write-back and wraps to 0 at 2**ring_code_i. Descriptor reads never leave the ring.
- R10: A byte at an even address goes to data bits 7:0 and a byte at an odd address to bits 15:8. Neighbouring bytes outside the packet are preserved through byte enables, for odd start addresses and odd lengths alike.
- R11: While `rx_on_i` is low, `s_ready_o` is low and no new descriptor is fetched. A write already in flight completes, and a packet interrupted this way resumes when `rx_on_i` returns.
- R12: After reset, `mem_req_o`, `s_ready_o` and `rint_o` are low and the ring index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_on_i | input | 1 | Receive enable |
| ring_base_i | input | 24 | Byte address of descriptor 0 |
| ring_code_i | input | 3 | Ring holds 2**code descriptors |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Byte is the packet's last |
| s_ready_o | output | 1 | Engine accepts a byte this cycle |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | 24 | Byte address, bit 0 zero for word access |
| mem_wdata_o | output | 16 | Write data |
| mem_be_o | output | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| mem_rdata_i | input | 16 | Read data, one cycle after a read request |
| rint_o | output | 1 | Packet-complete pulse |

## Verification
A wrong ring index shows up at the next descriptor fetch: data lands in another host buffer, or a descriptor outside the ring is overwritten, and the descriptor words read back after the packet expose it. A stale start or end flag, or a wrong length counter, shows in the written-back w1 and w3 once the packet's last descriptor is returned. A packer that loses a pending byte corrupts the buffer only at its odd or final position. The neighbouring guard bytes reveal this as soon as the packet completes. A wrong halt or ownership decision shows within the first cycles of the stall as an early `s_ready_o` or a stray write.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int unsigned ADDR_W  = 24;
  localparam int unsigned BLEN_W  = 13;
  localparam int unsigned MIN_BUF = 12;
  localparam int unsigned MAX_BUF = 1900;
  localparam int unsigned LEN_PAD = 4;
  localparam int unsigned OWN_B   = 15;
  localparam int unsigned STP_B   = 9;
  localparam int unsigned ENP_B   = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_SETTLE, S_EVAL, S_FILL, S_FLUSH, S_WB, S_HALT
  } rx_state_e;
endpackage

// File: rtl/rx_ring_index.sv
module rx_ring_index #(
  parameter int unsigned CODE_W = 3,
  localparam int unsigned IDX_W = (1 << CODE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [IDX_W+2:0]  desc_off_o
);
  logic [IDX_W-1:0] idx_q, mask;

  always_comb begin
    for (int b = 0; b < IDX_W; b++) mask[b] = (b < int'(code_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (adv_i) idx_q <= (idx_q + 1'b1) & mask;
  end

  assign desc_off_o = {idx_q, 3'b000};
endmodule

// File: rtl/rx_byte_packer.sv
module rx_byte_packer
  import rx_ring_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              flush_i,
  output logic              wr_v_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [15:0]       wr_data_o,
  output logic [1:0]        wr_be_o
);
  logic       pend_v_q;
  logic [7:0] pend_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_v_o    <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wr_be_o   <= '0;
      pend_v_q  <= 1'b0;
      pend_b_q  <= '0;
    end else begin
      wr_v_o <= 1'b0;
      if (push_i) begin
        if (addr_i[0]) begin
          // odd lane closes the word, pairing with a held even byte if any
          wr_v_o    <= 1'b1;
          wr_addr_o <= {addr_i[ADDR_W-1:1], 1'b0};
          wr_data_o <= {byte_i, pend_b_q};
          wr_be_o   <= {1'b1, pend_v_q};
          pend_v_q  <= 1'b0;
        end else if (flush_i) begin
          wr_v_o    <= 1'b1;
          wr_addr_o <= addr_i;
          wr_data_o <= {8'h00, byte_i};
          wr_be_o   <= 2'b01;
          pend_v_q  <= 1'b0;
        end else begin
          pend_v_q  <= 1'b1;
          pend_b_q  <= byte_i;
        end
      end
    end
  end
endmodule

// File: rtl/rx_desc_check.sv
module rx_desc_check
  import rx_ring_pkg::*;
(
  input  logic [15:0]       w0_i,
  input  logic [7:0]        addr_hi_i,
  input  logic              own_i,
  input  logic [15:0]       w2_i,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [BLEN_W-1:0] buf_len_o,
  output logic              usable_o,
  output logic              len_ok_o
);
  assign buf_addr_o = {addr_hi_i, w0_i};
  assign buf_len_o  = BLEN_W'(4096) - {1'b0, w2_i[11:0]};
  assign usable_o   = own_i && (w2_i[15:12] == 4'hF);
  assign len_ok_o   = (buf_len_o >= BLEN_W'(MIN_BUF)) && (buf_len_o <= BLEN_W'(MAX_BUF));
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
  import rx_ring_pkg::*;
#(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned LEN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_on_i,
  input  logic [ADDR_W-1:0] ring_base_i,
  input  logic [CODE_W-1:0] ring_code_i,
  input  logic              s_valid_i,
  input  logic [7:0]        s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  output logic [1:0]        mem_be_o,
  input  logic [15:0]       mem_rdata_i,
  output logic              rint_o
);
  localparam int unsigned IDX_W = (1 << CODE_W) - 1;

  rx_state_e         state_q;
  logic [1:0]        word_q, rd_k_q;
  logic              rd_v_q;
  logic [15:0]       dw_q [4];
  logic [ADDR_W-1:0] buf_addr_q;
  logic [BLEN_W-1:0] rem_q;
  logic [LEN_W-1:0]  pkt_len_q;
  logic              first_q, ended_q, rint_q;

  logic [IDX_W+2:0]  desc_off;
  logic [ADDR_W-1:0] desc_base, fsm_addr, dc_addr;
  logic [BLEN_W-1:0] dc_len;
  logic              dc_usable, dc_len_ok;
  logic              accept, buf_end, idx_adv, fsm_req, halt_s;
  logic              pk_wr_v;
  logic [ADDR_W-1:0] pk_addr;
  logic [15:0]       pk_data, wb_data;
  logic [1:0]        pk_be;

  rx_ring_index #(.CODE_W(CODE_W)) u_idx (
    .clk_i, .rst_ni, .adv_i(idx_adv), .code_i(ring_code_i), .desc_off_o(desc_off)
  );

  rx_desc_check u_chk_desc (
    .w0_i(dw_q[0]), .addr_hi_i(dw_q[1][7:0]), .own_i(dw_q[1][OWN_B]), .w2_i(dw_q[2]),
    .buf_addr_o(dc_addr), .buf_len_o(dc_len), .usable_o(dc_usable), .len_ok_o(dc_len_ok)
  );

  rx_byte_packer u_pack (
    .clk_i, .rst_ni, .push_i(accept), .byte_i(s_data_i), .addr_i(buf_addr_q),
    .flush_i(buf_end), .wr_v_o(pk_wr_v), .wr_addr_o(pk_addr), .wr_data_o(pk_data),
    .wr_be_o(pk_be)
  );

  assign desc_base = ring_base_i + ADDR_W'(desc_off);
  assign fsm_addr  = desc_base + ADDR_W'({word_q, 1'b0});
  assign s_ready_o = (state_q == S_FILL) && rx_on_i;
  assign accept    = s_ready_o && s_valid_i;
  assign buf_end   = s_last_i || (rem_q == BLEN_W'(1));
  assign fsm_req   = (state_q == S_FETCH) || (state_q == S_WB);
  assign idx_adv   = (state_q == S_WB) && (word_q == 2'd3);
  assign halt_s    = (state_q == S_HALT);
  assign rint_o    = rint_q;

  always_comb begin
    unique case (word_q)
      2'd1:    wb_data = {1'b0, dw_q[1][14:10], first_q, ended_q, dw_q[1][7:0]};
      2'd2:    wb_data = dw_q[2];
      2'd3:    wb_data = ended_q ? {dw_q[3][15:12], pkt_len_q + LEN_W'(LEN_PAD)} : dw_q[3];
      default: wb_data = '0;
    endcase
  end

  // packer writes and descriptor traffic never overlap: FSM is in FILL/FLUSH when packer writes
  assign mem_req_o   = pk_wr_v || fsm_req;
  assign mem_we_o    = pk_wr_v || (state_q == S_WB);
  assign mem_addr_o  = pk_wr_v ? pk_addr : fsm_addr;
  assign mem_wdata_o = pk_wr_v ? pk_data : wb_data;
  assign mem_be_o    = pk_wr_v ? pk_be : 2'b11;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_v_q <= 1'b0;
      rd_k_q <= '0;
      for (int k = 0; k < 4; k++) dw_q[k] <= '0;
    end else begin
      rd_v_q <= (state_q == S_FETCH);
      rd_k_q <= word_q;
      if (rd_v_q) dw_q[rd_k_q] <= mem_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      word_q     <= '0;
      buf_addr_q <= '0;
      rem_q      <= '0;
      pkt_len_q  <= '0;
      first_q    <= 1'b1;
      ended_q    <= 1'b0;
      rint_q     <= 1'b0;
    end else begin
      rint_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (rx_on_i && (s_valid_i || !first_q)) begin
          state_q <= S_FETCH;
          word_q  <= '0;
        end
        S_FETCH: begin
          word_q <= word_q + 1'b1;
          if (word_q == 2'd3) state_q <= S_SETTLE;
        end
        S_SETTLE: state_q <= S_EVAL;
        S_EVAL: begin
          word_q <= '0;
          if (!dc_usable)      state_q <= rx_on_i ? S_FETCH : S_IDLE;
          else if (!dc_len_ok) state_q <= S_HALT;
          else begin
            state_q    <= S_FILL;
            buf_addr_q <= dc_addr;
            rem_q      <= dc_len;
          end
        end
        S_FILL: if (accept) begin
          buf_addr_q <= buf_addr_q + 1'b1;
          rem_q      <= rem_q - 1'b1;
          pkt_len_q  <= pkt_len_q + 1'b1;
          if (s_last_i) ended_q <= 1'b1;
          if (buf_end)  state_q <= S_FLUSH;
        end
        S_FLUSH: begin
          state_q <= S_WB;
          word_q  <= 2'd1;
        end
        S_WB: begin
          word_q <= word_q + 1'b1;
          if (word_q == 2'd3) begin
            word_q <= '0;
            if (ended_q) begin
              rint_q    <= 1'b1;
              first_q   <= 1'b1;
              ended_q   <= 1'b0;
              pkt_len_q <= '0;
              state_q   <= S_IDLE;
            end else begin
              first_q <= 1'b0;
              state_q <= rx_on_i ? S_FETCH : S_IDLE;
            end
          end
        end
        S_HALT: if (!rx_on_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_engine_chk.sv
module rx_ring_engine_chk
  import rx_ring_pkg::*;
#(
  parameter int unsigned CODE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [15:0]       mem_wdata_o,
  input logic [1:0]        mem_be_o,
  input logic [ADDR_W-1:0] ring_base_i,
  input logic [CODE_W-1:0] ring_code_i,
  input logic              rint_o,
  input logic              s_ready_o,
  input logic              halt_s,
  input logic              pk_wr_v,
  input logic              fsm_req
);
  logic [ADDR_W-1:0] ring_off, ring_size;
  assign ring_off  = mem_addr_o - ring_base_i;
  assign ring_size = ADDR_W'(8) << ring_code_i;

  a_r3_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_s |-> (!mem_req_o && !s_ready_o));

  a_r7_own_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && ring_off < ring_size && ring_off[2:0] == 3'd2) |-> !mem_wdata_o[15]);

  a_r8_rint_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rint_o |=> !rint_o);

  a_r8_rint_after_w3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rint_o |-> $past(mem_req_o && mem_we_o && ring_off[2:0] == 3'd6));

  a_r9_read_in_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (ring_off < ring_size));

  a_r10_be_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_be_o != 2'b00));

  a_r10_port_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pk_wr_v && fsm_req));
endmodule

bind rx_ring_engine rx_ring_engine_chk #(.CODE_W(CODE_W)) u_rx_ring_engine_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o),
  .ring_base_i(ring_base_i), .ring_code_i(ring_code_i), .rint_o(rint_o),
  .s_ready_o(s_ready_o), .halt_s(halt_s), .pk_wr_v(pk_wr_v), .fsm_req(fsm_req)
);

// File: tb/tb_rx_ring_engine.sv
module tb_rx_ring_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_on_i = 1'b0;
  logic [23:0] ring_base_i = 24'h000100;
  logic [2:0]  ring_code_i = 3'd2;
  logic        s_valid_i = 1'b0;
  logic [7:0]  s_data_i = '0;
  logic        s_last_i = 1'b0;
  logic        s_ready_o, mem_req_o, mem_we_o, rint_o;
  logic [23:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic [1:0]  mem_be_o;
  logic [15:0] mem_rdata_i = '0;

  int n_chk = 0, n_err = 0, wr_cnt = 0, rint_cnt = 0;
  logic rint_d = 1'b0, rint_wide = 1'b0, hi_seen = 1'b0;
  logic [15:0] mem_w [0:4095];

  always #4 clk_i = ~clk_i;

  rx_ring_engine dut (.*);

  // memory model: one-cycle read latency, byte-enabled writes
  always @(posedge clk_i) begin
    if (mem_req_o && mem_we_o) begin
      if (mem_be_o[0]) mem_w[mem_addr_o[12:1]][7:0]  <= mem_wdata_o[7:0];
      if (mem_be_o[1]) mem_w[mem_addr_o[12:1]][15:8] <= mem_wdata_o[15:8];
      wr_cnt++;
      if (mem_addr_o[23:16] != 8'h00) hi_seen = 1'b1;
    end
    if (mem_req_o && !mem_we_o) mem_rdata_i <= mem_w[mem_addr_o[12:1]];
    if (rint_o) rint_cnt++;
    if (rint_o && rint_d) rint_wide = 1'b1;
    rint_d <= rint_o;
  end

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: run hung, act=running exp=done");
    finish_up();
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed * 7 + i * 13 + 1);
  endfunction

  function automatic logic [7:0] rd_b(int a);
    return a[0] ? mem_w[a[12:1]][15:8] : mem_w[a[12:1]][7:0];
  endfunction

  function automatic logic [15:0] rd_w(int a);
    return mem_w[a[12:1]];
  endfunction

  function automatic int cmp(int a, int n, int seed, int i0);
    int bad = 0;
    for (int i = 0; i < n; i++) if (rd_b(a + i) !== pat(seed, i0 + i)) bad++;
    return bad;
  endfunction

  task automatic fill(int a, int n, logic [7:0] v);
    for (int i = 0; i < n; i++) begin
      if ((a + i) % 2 == 1) mem_w[(a + i) / 2][15:8] = v;
      else                  mem_w[(a + i) / 2][7:0]  = v;
    end
  endtask

  function automatic int dw(int i, int j);
    return 'h100 + 8 * i + 2 * j;
  endfunction

  // w1 carries host bit 13 and stale start/end flags to show they are rewritten
  task automatic set_desc(int i, logic [23:0] ba, int len, bit own, logic [3:0] nib);
    mem_w[dw(i, 0) / 2] = ba[15:0];
    mem_w[dw(i, 1) / 2] = {own, 5'b01000, 2'b11, ba[23:16]};
    mem_w[dw(i, 2) / 2] = {nib, 12'(4096 - len)};
    mem_w[dw(i, 3) / 2] = 16'hA000;
  endtask

  task automatic send_pkt(int n, int seed, int drop_at, int lim);
    bit rdy;
    int waitc, hi, snap;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      s_valid_i = 1'b1;
      s_data_i  = pat(seed, i);
      s_last_i  = (i == n - 1);
      waitc = 0;
      forever begin
        rdy = s_ready_o;
        @(posedge clk_i);
        if (rdy) break;
        @(negedge clk_i);
        waitc++;
        if (waitc > lim) begin
          s_valid_i = 1'b0;
          s_last_i  = 1'b0;
          return;
        end
      end
      if (i == drop_at) begin
        @(negedge clk_i);
        rx_on_i = 1'b0;
        s_valid_i = 1'b0;
        repeat (3) @(negedge clk_i);
        snap = wr_cnt;
        hi = 0;
        repeat (20) begin
          @(negedge clk_i);
          if (s_ready_o) hi++;
        end
        chk("R11 ready low while disabled", hi, 0);
        chk("R11 no writes while disabled", wr_cnt, snap);
        rx_on_i = 1'b1;
      end
    end
    @(negedge clk_i);
    s_valid_i = 1'b0;
    s_last_i  = 1'b0;
  endtask

  task automatic wait_rint(string tag);
    int start = rint_cnt;
    int t = 0;
    while (rint_cnt == start && t < 2000) begin
      @(negedge clk_i);
      t++;
    end
    repeat (6) @(negedge clk_i);
    chk(tag, rint_cnt - start, 1);
  endtask

  task automatic t_reset();
    chk("R12 mem_req after reset", mem_req_o, 0);
    chk("R12 ready after reset", s_ready_o, 0);
    chk("R12 rint after reset", rint_o, 0);
  endtask

  task automatic t_single();
    fill('h400, 64, 8'h00);
    set_desc(0, 24'h000400, 64, 1'b1, 4'hF);
    send_pkt(20, 1, -1, 400);
    wait_rint("R8 one pulse single packet");
    chk("R1 R10 single data", cmp('h400, 20, 1, 0), 0);
    chk("R4 no byte past end", rd_b('h414), 0);
    chk("R5 R6 R7 desc0 w1", rd_w(dw(0, 1)), 16'h2300);
    chk("R6 desc0 w2 kept", rd_w(dw(0, 2)), 16'hFFC0);
    chk("R6 desc0 w3 length", rd_w(dw(0, 3)), 16'hA018);
  endtask

  task automatic t_span();
    hi_seen = 1'b0;
    set_desc(1, 24'h010800, 12, 1'b1, 4'hF);
    set_desc(2, 24'h000900, 12, 1'b1, 4'hF);
    set_desc(3, 24'h000A00, 12, 1'b1, 4'hF);
    fill('h800, 16, 8'h00);
    fill('h900, 16, 8'h00);
    fill('hA00, 16, 8'h00);
    send_pkt(30, 2, -1, 400);
    wait_rint("R8 one pulse for spanning packet");
    chk("R1 upper address byte used", hi_seen, 1);
    chk("R4 first buffer data", cmp('h800, 12, 2, 0), 0);
    chk("R4 second buffer data", cmp('h900, 12, 2, 12), 0);
    chk("R4 third buffer data", cmp('hA00, 6, 2, 24), 0);
    chk("R4 third buffer stops", rd_b('hA06), 0);
    chk("R5 first desc start flag", rd_w(dw(1, 1)), 16'h2201);
    chk("R5 R6 middle desc flags", rd_w(dw(2, 1)), 16'h2000);
    chk("R6 last desc end flag", rd_w(dw(3, 1)), 16'h2100);
    chk("R6 first desc w3 untouched", rd_w(dw(1, 3)), 16'hA000);
    chk("R6 last desc length", rd_w(dw(3, 3)), 16'hA022);
  endtask

  task automatic t_wrap();
    set_desc(0, 24'h000601, 100, 1'b1, 4'hF);
    fill('h600, 8, 8'hEE);
    for (int j = 0; j < 4; j++) mem_w[dw(4, j) / 2] = 16'h1234;
    send_pkt(5, 3, -1, 400);
    wait_rint("R9 packet taken by wrapped index");
    chk("R10 byte before odd start kept", rd_b('h600), 8'hEE);
    chk("R10 odd start data", cmp('h601, 5, 3, 0), 0);
    chk("R10 byte after end kept", rd_b('h606), 8'hEE);
    chk("R9 desc0 reused", rd_w(dw(0, 3)), 16'hA009);
    chk("R9 slot past ring untouched", {rd_w(dw(4, 1)), rd_w(dw(4, 3))}, 32'h12341234);
  endtask

  task automatic t_own();
    int hi, snap;
    set_desc(1, 24'h000B00, 40, 1'b0, 4'hF);
    fill('hB00, 16, 8'hEE);
    snap = wr_cnt;
    fork
      send_pkt(7, 4, -1, 400);
    join_none
    hi = 0;
    repeat (40) begin
      @(negedge clk_i);
      if (s_ready_o) hi++;
    end
    chk("R2 held while not owned", hi, 0);
    chk("R2 no writes while not owned", wr_cnt, snap);
    set_desc(1, 24'h000B00, 40, 1'b1, 4'hE);
    hi = 0;
    repeat (40) begin
      @(negedge clk_i);
      if (s_ready_o) hi++;
    end
    chk("R2 held on bad mark nibble", hi, 0);
    chk("R2 no writes on bad mark", wr_cnt, snap);
    set_desc(1, 24'h000B00, 40, 1'b1, 4'hF);
    wait_rint("R2 proceeds once owned");
    wait fork;
    chk("R2 R10 data odd length", cmp('hB00, 7, 4, 0), 0);
    chk("R10 high lane after odd end kept", rd_b('hB07), 8'hEE);
    chk("R6 desc1 length odd", rd_w(dw(1, 3)), 16'hA00B);
  endtask

  task automatic t_rxoff();
    set_desc(2, 24'h000C00, 64, 1'b1, 4'hF);
    fill('hC00, 16, 8'h00);
    send_pkt(10, 5, 3, 400);
    wait_rint("R11 packet resumes");
    chk("R11 data after resume", cmp('hC00, 10, 5, 0), 0);
    chk("R11 length after resume", rd_w(dw(2, 3)), 16'hA00E);
  endtask

  task automatic t_badlen();
    int hi, snap;
    int bad_len[2] = '{11, 1901};
    foreach (bad_len[k]) begin
      set_desc(3, 24'h000D00, bad_len[k], 1'b1, 4'hF);
      snap = wr_cnt;
      fork
        send_pkt(4, 6, -1, 60);
      join_none
      hi = 0;
      repeat (50) begin
        @(negedge clk_i);
        if (s_ready_o) hi++;
      end
      wait fork;
      chk("R3 stopped: ready low", hi, 0);
      chk("R3 stopped: no writes", wr_cnt, snap);
      chk("R3 descriptor left owned", rd_w(dw(3, 1)), 16'hA300);
      @(negedge clk_i);
      rx_on_i = 1'b0;
      repeat (3) @(negedge clk_i);
      rx_on_i = 1'b1;
      repeat (2) @(negedge clk_i);
    end
    set_desc(3, 24'h000D00, 12, 1'b1, 4'hF);
    fill('hD00, 16, 8'h00);
    send_pkt(6, 7, -1, 400);
    wait_rint("R3 recovers after re-enable");
    chk("R3 data after recovery", cmp('hD00, 6, 7, 0), 0);
    chk("R3 length after recovery", rd_w(dw(3, 3)), 16'hA00A);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem_w[i] = '0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    rx_on_i = 1'b1;
    t_single();
    t_span();
    t_wrap();
    t_own();
    t_rxoff();
    t_badlen();
    chk("R8 rint never wider than one cycle", rint_wide, 0);
    finish_up();
  end
endmodule